// File: doc/BRIEF.md
# Ternary-Match Packet Flow Classifier

This block sorts IPv4 packets into flows. A header parser ahead of it presents the packet's addresses, ports, protocol number and a one-byte content-match code from a separate payload scanner. The block packs these into a single 112-bit key. It compares that key against every entry of a small rule table in the same cycle, and reports the flow identifier of the winning rule one clock later.

Each rule holds a 112-bit pattern, a 112-bit care-mask, a 16-bit flow identifier and a live flag. Key bits whose mask bit is clear are wildcards. This lets one rule express an address prefix, a port wildcard and an exact protocol value all at once. When several rules match, the rule at the lowest table index wins. Rules are loaded or retired through a single-cycle write port.

Top module: `flow_classifier_tcam`

## Requirements
- R1: After reset, result_valid, result_hit and result_flow_id are all zero, and every table entry is dead, so the first lookup misses.
- R2: A lookup presented with key_valid high at a rising edge produces result_valid high after exactly that edge. result_valid is low after any edge at which key_valid was low.
- R3: An entry matches when, for every key bit whose mask bit is 1, the key bit equals the pattern bit. Key bits whose mask bit is 0 are ignored.
- R4: The 112-bit key, pattern and mask share one layout: source address [111:80], destination address [79:48], source port [47:32], destination port [31:16], protocol [15:8], content code [7:0].
- R5: When several live entries match, result_flow_id carries the flow identifier of the lowest-numbered matching entry, and result_hit is 1.
- R6: When no live entry matches, result_hit is 0 and result_flow_id is zero while result_valid is 1.
- R7: A write sets the entry's live flag to wr_live. An entry whose live flag is 0 never matches.
- R8: A write accepted at a rising edge is seen by lookups from the next edge onward. A lookup at the same edge as the write sees the table as it was before the write.
- R9: While result_valid is low, result_hit and result_flow_id are zero.
- R10: A rule that masks the low 16 bits of the source address, wildcards the source port and requires protocol 6 matches any packet in that /16 prefix with protocol 6 and any source port. It rejects other protocols and other prefixes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_valid | input | 1 | Lookup request this cycle |
| key_src_ip | input | 32 | Source IPv4 address |
| key_dst_ip | input | 32 | Destination IPv4 address |
| key_src_port | input | 16 | Source L4 port |
| key_dst_port | input | 16 | Destination L4 port |
| key_proto | input | 8 | IP protocol number |
| key_content | input | 8 | Payload content-match code |
| wr_en | input | 1 | Table write strobe |
| wr_index | input | IDX_W | Entry index to write |
| wr_live | input | 1 | Live flag written to the entry |
| wr_value | input | 112 | Match pattern |
| wr_mask | input | 112 | Care-mask, 1 = bit compared |
| wr_flow_id | input | 16 | Flow identifier of the entry |
| result_valid | output | 1 | Lookup result present |
| result_hit | output | 1 | Some live entry matched |
| result_flow_id | output | 16 | Winning flow identifier, zero on miss |

## Verification
The bench builds the block with its default of eight entries. Writes can therefore land at index 0, at the top index 7 and at interior slots, which lets the checks cover a rule at the bottom of the priority order and overlapping rules at both ends. With eight slots, a catch-all rule, a /16 prefix rule, rules that test one field each, and an exact rule can all be live together. Each lookup is therefore resolved by priority among several candidates, and a retired rule falls through to the next one.

// File: rtl/flowcls_pkg.sv
package flowcls_pkg;
    localparam int SIP_W   = 32;
    localparam int DIP_W   = 32;
    localparam int SPORT_W = 16;
    localparam int DPORT_W = 16;
    localparam int PROTO_W = 8;
    localparam int CONT_W  = 8;
    localparam int KEY_W   = SIP_W + DIP_W + SPORT_W + DPORT_W + PROTO_W + CONT_W;
    localparam int FID_W   = 16;

    // Field order, most significant first, fixes the key layout.
    typedef struct packed {
        logic [SIP_W-1:0]   src_ip;
        logic [DIP_W-1:0]   dst_ip;
        logic [SPORT_W-1:0] src_port;
        logic [DPORT_W-1:0] dst_port;
        logic [PROTO_W-1:0] proto;
        logic [CONT_W-1:0]  content;
    } flow_key_t;
endpackage

// File: rtl/fc_entry_table.sv
module fc_entry_table
    import flowcls_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int IDX_W     = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [IDX_W-1:0]                wr_index,
    input  logic                            wr_live,
    input  logic [KEY_W-1:0]                wr_value,
    input  logic [KEY_W-1:0]                wr_mask,
    input  logic [FID_W-1:0]                wr_flow_id,
    output logic [N_ENTRIES-1:0]            live_o,
    output logic [N_ENTRIES-1:0][KEY_W-1:0] value_o,
    output logic [N_ENTRIES-1:0][KEY_W-1:0] mask_o,
    output logic [N_ENTRIES-1:0][FID_W-1:0] fid_o
);
    typedef struct packed {
        logic [N_ENTRIES-1:0]            live;
        logic [N_ENTRIES-1:0][KEY_W-1:0] value;
        logic [N_ENTRIES-1:0][KEY_W-1:0] mask;
        logic [N_ENTRIES-1:0][FID_W-1:0] fid;
    } table_t;

    table_t tbl_d, tbl_q;
    logic   wr_ok;

    always_comb begin
        wr_ok = wr_en && (32'(wr_index) < N_ENTRIES);
        tbl_d = tbl_q;
        if (wr_ok) begin
            tbl_d.live[wr_index]  = wr_live;
            tbl_d.value[wr_index] = wr_value;
            tbl_d.mask[wr_index]  = wr_mask;
            tbl_d.fid[wr_index]   = wr_flow_id;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    assign live_o  = tbl_q.live;
    assign value_o = tbl_q.value;
    assign mask_o  = tbl_q.mask;
    assign fid_o   = tbl_q.fid;

    assert_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> (live_o[$past(wr_index)] == $past(wr_live))
                  && (fid_o[$past(wr_index)] == $past(wr_flow_id)));

    assert_no_write_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(live_o));
endmodule

// File: rtl/fc_match_array.sv
module fc_match_array
    import flowcls_pkg::*;
#(
    parameter int N_ENTRIES = 8
) (
    input  logic [KEY_W-1:0]                key,
    input  logic [N_ENTRIES-1:0]            live,
    input  logic [N_ENTRIES-1:0][KEY_W-1:0] value,
    input  logic [N_ENTRIES-1:0][KEY_W-1:0] mask,
    output logic [N_ENTRIES-1:0]            hits
);
    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
        logic [KEY_W-1:0] diff;
        always_comb begin
            diff    = (key ^ value[g]) & mask[g];
            hits[g] = live[g] && (diff == '0);
        end
    end
endmodule

// File: rtl/fc_prio_pick.sv
module fc_prio_pick #(
    parameter int N_ENTRIES = 8,
    parameter int IDX_W     = 3
) (
    input  logic [N_ENTRIES-1:0] req,
    output logic                 any,
    output logic [IDX_W-1:0]     idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/flow_classifier_tcam.sv
module flow_classifier_tcam
    import flowcls_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               key_valid,
    input  logic [SIP_W-1:0]   key_src_ip,
    input  logic [DIP_W-1:0]   key_dst_ip,
    input  logic [SPORT_W-1:0] key_src_port,
    input  logic [DPORT_W-1:0] key_dst_port,
    input  logic [PROTO_W-1:0] key_proto,
    input  logic [CONT_W-1:0]  key_content,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_index,
    input  logic               wr_live,
    input  logic [KEY_W-1:0]   wr_value,
    input  logic [KEY_W-1:0]   wr_mask,
    input  logic [FID_W-1:0]   wr_flow_id,
    output logic               result_valid,
    output logic               result_hit,
    output logic [FID_W-1:0]   result_flow_id
);
    typedef struct packed {
        logic             valid;
        logic             hit;
        logic [FID_W-1:0] fid;
    } result_t;

    flow_key_t                       key_s;
    logic [N_ENTRIES-1:0]            tbl_live;
    logic [N_ENTRIES-1:0][KEY_W-1:0] tbl_value;
    logic [N_ENTRIES-1:0][KEY_W-1:0] tbl_mask;
    logic [N_ENTRIES-1:0][FID_W-1:0] tbl_fid;
    logic [N_ENTRIES-1:0]            match;
    logic [N_ENTRIES-1:0]            below_pick;
    logic                            pick_any;
    logic [IDX_W-1:0]                pick_idx;
    result_t                         res_d, res_q;

    always_comb begin
        key_s.src_ip   = key_src_ip;
        key_s.dst_ip   = key_dst_ip;
        key_s.src_port = key_src_port;
        key_s.dst_port = key_dst_port;
        key_s.proto    = key_proto;
        key_s.content  = key_content;
    end

    fc_entry_table #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_index   (wr_index),
        .wr_live    (wr_live),
        .wr_value   (wr_value),
        .wr_mask    (wr_mask),
        .wr_flow_id (wr_flow_id),
        .live_o     (tbl_live),
        .value_o    (tbl_value),
        .mask_o     (tbl_mask),
        .fid_o      (tbl_fid)
    );

    fc_match_array #(.N_ENTRIES(N_ENTRIES)) u_match (
        .key   (key_s),
        .live  (tbl_live),
        .value (tbl_value),
        .mask  (tbl_mask),
        .hits  (match)
    );

    fc_prio_pick #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_pick (
        .req (match),
        .any (pick_any),
        .idx (pick_idx)
    );

    always_comb begin
        below_pick = (N_ENTRIES'(1) << pick_idx) - N_ENTRIES'(1);
        res_d.valid = key_valid;
        res_d.hit   = key_valid && pick_any;
        res_d.fid   = res_d.hit ? tbl_fid[pick_idx] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign result_valid   = res_q.valid;
    assign result_hit     = res_q.hit;
    assign result_flow_id = res_q.fid;

    assert_result_follows_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |=> result_valid);

    assert_no_spurious_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !key_valid |=> !result_valid);

    assert_idle_outputs_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> (!result_hit && result_flow_id == '0));

    assert_miss_fid_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && !result_hit) |-> result_flow_id == '0);

    assert_pick_is_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pick_any |-> match[pick_idx]);

    assert_pick_lowest_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pick_any |-> (match & below_pick) == '0);

    assert_flow_from_winner_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid && pick_any) |=> (result_hit && result_flow_id == $past(tbl_fid[pick_idx])));

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_dead_chk
        assert_dead_entry_never_matches_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !tbl_live[g] |-> !match[g]);
    end
endmodule

// File: tb/flow_classifier_tcam_bench.sv
`timescale 1ns/1ps
module flow_classifier_tcam_bench;
    import flowcls_pkg::*;

    localparam int N  = 8;
    localparam int IW = 3;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             key_valid;
    logic [31:0]      key_src_ip, key_dst_ip;
    logic [15:0]      key_src_port, key_dst_port;
    logic [7:0]       key_proto, key_content;
    logic             wr_en, wr_live;
    logic [IW-1:0]    wr_index;
    logic [KEY_W-1:0] wr_value, wr_mask;
    logic [15:0]      wr_flow_id;
    logic             result_valid, result_hit;
    logic [15:0]      result_flow_id;

    always #10 clk = ~clk;

    flow_classifier_tcam #(.N_ENTRIES(N)) u_flow_classifier_tcam (
        .clk(clk), .rst_n(rst_n), .key_valid(key_valid),
        .key_src_ip(key_src_ip), .key_dst_ip(key_dst_ip),
        .key_src_port(key_src_port), .key_dst_port(key_dst_port),
        .key_proto(key_proto), .key_content(key_content),
        .wr_en(wr_en), .wr_index(wr_index), .wr_live(wr_live),
        .wr_value(wr_value), .wr_mask(wr_mask), .wr_flow_id(wr_flow_id),
        .result_valid(result_valid), .result_hit(result_hit),
        .result_flow_id(result_flow_id)
    );

    // Reference table, updated from the requirements.
    bit             m_live [N];
    bit [KEY_W-1:0] m_val  [N];
    bit [KEY_W-1:0] m_msk  [N];
    bit [15:0]      m_fid  [N];

    typedef struct {
        bit        hit;
        bit [15:0] fid;
        string     tag;
    } exp_t;
    exp_t sbq[$];

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    // R4 layout: src[111:80] dst[79:48] sport[47:32] dport[31:16] proto[15:8] content[7:0]
    function automatic bit [KEY_W-1:0] pk(bit [31:0] s, bit [31:0] d, bit [15:0] sp,
                                          bit [15:0] dp, bit [7:0] pr, bit [7:0] ct);
        return {s, d, sp, dp, pr, ct};
    endfunction

    task automatic cyc(input bit lk, input bit [KEY_W-1:0] k, input bit we, input int idx,
                       input bit [KEY_W-1:0] v, input bit [KEY_W-1:0] m,
                       input bit [15:0] f, input bit wl, input string tag);
        exp_t e;
        key_valid = lk;
        {key_src_ip, key_dst_ip, key_src_port, key_dst_port, key_proto, key_content} = k;
        wr_en = we; wr_index = IW'(idx); wr_value = v; wr_mask = m;
        wr_flow_id = f; wr_live = wl;
        if (lk) begin
            e.hit = 0; e.fid = '0; e.tag = tag;
            for (int i = N - 1; i >= 0; i--) begin
                if (m_live[i] && (((k ^ m_val[i]) & m_msk[i]) == '0)) begin
                    e.hit = 1; e.fid = m_fid[i];
                end
            end
            sbq.push_back(e);
        end
        if (we) begin
            m_live[idx] = wl; m_val[idx] = v; m_msk[idx] = m; m_fid[idx] = f;
        end
        @(negedge clk);
        key_valid = 1'b0;
        wr_en     = 1'b0;
    endtask

    task automatic lookup(input bit [KEY_W-1:0] k, input string tag);
        cyc(1'b1, k, 1'b0, 0, '0, '0, 16'h0, 1'b0, tag);
    endtask

    task automatic put(input int idx, input bit [KEY_W-1:0] v, input bit [KEY_W-1:0] m,
                       input bit [15:0] f, input bit wl);
        cyc(1'b0, '0, 1'b1, idx, v, m, f, wl, "write");
    endtask

    // Monitor: pops the scoreboard as results appear.
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && !done) begin
            if (result_valid) begin
                n_vec++;
                if (sbq.size() == 0) begin
                    n_bad++;
                    $display("FAIL R2: result_valid=1 with no lookup pending, expected 0");
                end else begin
                    e = sbq.pop_front();
                    if (result_hit !== e.hit || result_flow_id !== e.fid) begin
                        n_bad++;
                        $display("FAIL %s: hit=%0b fid=%h, expected hit=%0b fid=%h",
                                 e.tag, result_hit, result_flow_id, e.hit, e.fid);
                    end
                end
            end else begin
                n_vec++;
                if (result_hit !== 1'b0 || result_flow_id !== 16'h0) begin
                    n_bad++;
                    $display("FAIL R9: idle hit=%0b fid=%h, expected hit=0 fid=0000",
                             result_hit, result_flow_id);
                end
            end
        end
    end

    initial begin
        bit [KEY_W-1:0] ka, ones;
        ones = '1;
        ka = pk(32'h80FC0505, 32'h8D8E0202, 16'h1000, 16'h0050, 8'h06, 8'h01);
        rst_n = 1'b0; key_valid = 0; wr_en = 0; wr_live = 0; wr_index = '0;
        wr_value = '0; wr_mask = '0; wr_flow_id = '0;
        {key_src_ip, key_dst_ip, key_src_port, key_dst_port, key_proto, key_content} = '0;
        repeat (3) @(negedge clk);
        n_vec++;
        if (result_valid !== 0 || result_hit !== 0 || result_flow_id !== 0) begin
            n_bad++;
            $display("FAIL R1: reset outputs v=%0b h=%0b fid=%h, expected 0 0 0000",
                     result_valid, result_hit, result_flow_id);
        end
        rst_n = 1'b1;
        @(negedge clk);

        lookup(ka, "R1 empty table misses");

        // Top index, exact rule
        put(7, ka, ones, 16'h7007, 1'b1);
        lookup(ka, "R3 exact rule at top index");

        // Prefix rule at index 3
        put(3, pk(32'h80FC0000, 32'h8D8E0000, 16'h0000, 16'h0050, 8'h06, 8'h01),
               pk(32'hFFFF0000, 32'hFFFF0000, 16'h0000, 16'hFFFF, 8'hFF, 8'hFF),
               16'h0103, 1'b1);
        lookup(ka, "R5 index 3 beats index 7");
        lookup(pk(32'h80FC0505, 32'h8D8E0202, 16'hBEEF, 16'h0050, 8'h06, 8'h01),
               "R10 wildcard source port");
        lookup(pk(32'h80FC0505, 32'h8D8E0202, 16'h1000, 16'h0050, 8'h11, 8'h01),
               "R10 R6 protocol 17 rejected, miss");
        lookup(pk(32'h80FD0505, 32'h8D8E0202, 16'h1000, 16'h0050, 8'h06, 8'h01),
               "R10 other prefix rejected");
        lookup(pk(32'h80FCFFFF, 32'h8D8E0001, 16'h1000, 16'h0050, 8'h06, 8'h01),
               "R10 low address bits ignored");

        // Catch-all rule
        put(5, '0, '0, 16'h0BEE, 1'b1);
        lookup(pk(32'h01020304, 32'h05060708, 16'h1000, 16'h0050, 8'h11, 8'h01),
               "R3 all-wildcard rule matches");
        lookup(ka, "R5 index 3 beats catch-all 5");

        // Field position rules
        put(0, pk(0, 0, 0, 0, 8'h00, 8'h5A), pk(0, 0, 0, 0, 8'h00, 8'hFF), 16'h0A00, 1'b1);
        put(1, pk(0, 0, 0, 16'h1234, 0, 0), pk(0, 0, 0, 16'hFFFF, 0, 0), 16'h0D01, 1'b1);
        lookup(pk(32'h11111111, 32'h22222222, 16'h3333, 16'h4444, 8'h55, 8'h5A),
               "R4 content code in low byte");
        lookup(pk(32'h11111111, 32'h22222222, 16'h3333, 16'h1234, 8'h55, 8'h00),
               "R4 destination port field");
        lookup(pk(32'h11111111, 32'h22222222, 16'h1234, 16'h4444, 8'h55, 8'h00),
               "R4 source port is not destination port");
        lookup(pk(32'h11111111, 32'h22222222, 16'h3333, 16'h4444, 8'h5A, 8'h00),
               "R4 protocol is not content");

        // Retire entry 0
        put(0, pk(0, 0, 0, 0, 8'h00, 8'h5A), pk(0, 0, 0, 0, 8'h00, 8'hFF), 16'h0A00, 1'b0);
        lookup(pk(32'h11111111, 32'h22222222, 16'h3333, 16'h4444, 8'h55, 8'h5A),
               "R7 dead entry 0 skipped");

        // Same-cycle write and lookup
        cyc(1'b1, ka, 1'b1, 2, '0, '0, 16'h0222, 1'b1, "R8 same-cycle lookup sees old table");
        lookup(ka, "R8 write visible next cycle");

        // Idle gap, then back-to-back lookups
        repeat (2) @(negedge clk);
        lookup(ka, "R2 back-to-back 1");
        lookup(pk(32'h80FC0505, 32'h8D8E0202, 16'h1000, 16'h0050, 8'h11, 8'h01),
               "R2 back-to-back 2");
        lookup(pk(32'h11111111, 32'h22222222, 16'h3333, 16'h1234, 8'h55, 8'h00),
               "R2 back-to-back 3");

        // Retire everything
        for (int i = 0; i < N; i++) put(i, '0, '0, 16'h0, 1'b0);
        lookup(ka, "R7 R6 all entries dead, miss");

        repeat (3) @(negedge clk);
        n_vec++;
        if (sbq.size() != 0) begin
            n_bad++;
            $display("FAIL R2: %0d lookups without result, expected 0", sbq.size());
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL R2: watchdog expired, got hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule